// File: doc/BRIEF.md
# Sticky Status and Latched Interrupt Controller

This block sits between a line transceiver datapath and a host register port. It watches two event pulses from the elastic store, one for overflow and one for underflow, and a vector of performance status levels. From these it keeps two sticky transition bits and drives a latched interrupt output. The interrupt output is active low and open-drain style: it has a data pin and an output enable, and it is released (high impedance) when nothing is pending.

The host reads the transition bits with a read strobe, which clears them. It controls interrupts through one clear register that does two jobs. Writing 1 to a bit acknowledges that source and also masks it for as long as the 1 stays. Writing 0 re-enables the source. A pending interrupt drops only when its clear bit is 1 and its cause is no longer present in that cycle. A global enable input gates the interrupts raised by changes in performance status.

Interrupt source index: bit 0 is overflow, bit 1 is underflow, and bits 2 upward are performance status bits 0 upward.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: A transition bit (tsr_q[0] for overflow, tsr_q[1] for underflow) is set on the clock edge after its pulse, and it stays set until a read strobe.
- R2: A read strobe (tsr_rd) clears both transition bits on the next edge, unless R3 applies.
- R3: If a pulse arrives in the same cycle as a read strobe, the new event wins and its bit is 1 after that edge.
- R4: An overflow or underflow pulse whose clear bit is 0 makes an interrupt pending on the next edge. The pending interrupt stays latched after the pulse ends.
- R5: While a source's clear bit is 1, that source raises no new interrupt. Its transition bit is still set.
- R6: A pending interrupt drops on the first edge where its clear bit is already registered as 1 and its cause is absent in that cycle. A write takes effect in clear register clr_q on the edge of the clr_wr strobe.
- R7: Writing 0 to a clear bit re-enables that source, so the next event raises an interrupt again.
- R8: When gie is 1, a rising or falling change of any perf_stat bit against its value in the previous cycle raises the interrupt of that bit.
- R9: When gie is 0, changes of perf_stat raise no interrupt.
- R10: irq_oe is 1 exactly when an interrupt is pending. irq_n is 0 whenever irq_oe is 1, and it is 1 otherwise.
- R11: Reset clears the transition bits, the pending latches, the clear register and the stored copy of the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovf_pulse | input | 1 | Elastic-store overflow event |
| unf_pulse | input | 1 | Elastic-store underflow event |
| perf_stat | input | PERF_W | Performance status levels |
| gie | input | 1 | Global enable for status-change interrupts |
| tsr_rd | input | 1 | Read strobe of the transition bits |
| clr_wr | input | 1 | Write strobe of the clear register |
| clr_wdata | input | PERF_W+2 | Write data for the clear register |
| tsr_q | output | 2 | Sticky transition bits {underflow, overflow} |
| clr_q | output | PERF_W+2 | Clear register contents |
| irq_n | output | 1 | Interrupt data, active low |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
The bench aims at the cycle where a read strobe and a new pulse coincide. A design that let the read win would lose an overflow there. It also holds the underflow cause active while its clear bit is already 1. A design that cleared on the write alone would drop the interrupt one cycle too early. A falling status edge and status changes while gie is low are both driven: a design that detected only rising edges would miss the first, and one that ignored gie would raise a false interrupt on the second. Re-enabling by writing 0, and a masked event that still sets its sticky bit, show whether the clear register is treated as a mask as well as an acknowledge.

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl #(
  parameter int PERF_W = 4,
  localparam int NSRC = PERF_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_pulse,
  input  logic              unf_pulse,
  input  logic [PERF_W-1:0] perf_stat,
  input  logic              gie,
  input  logic              tsr_rd,
  input  logic              clr_wr,
  input  logic [NSRC-1:0]   clr_wdata,
  output logic [1:0]        tsr_q,
  output logic [NSRC-1:0]   clr_q,
  output logic              irq_n,
  output logic              irq_oe
);

  logic [PERF_W-1:0] perf_d;
  logic [NSRC-1:0]   pend_q;
  logic [PERF_W-1:0] chg;
  logic [NSRC-1:0]   cause, raise, pend_nx;
  logic [1:0]        es_ev;

  assign es_ev   = {unf_pulse, ovf_pulse};
  assign chg     = perf_stat ^ perf_d;
  assign cause   = {chg, es_ev};
  assign raise   = {chg & {PERF_W{gie}}, es_ev} & ~clr_q;
  assign pend_nx = raise | (pend_q & ~(clr_q & ~cause));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsr_q  <= '0;
      clr_q  <= '0;
      pend_q <= '0;
      perf_d <= '0;
    end else begin
      tsr_q  <= es_ev | (tsr_q & {2{~tsr_rd}});
      pend_q <= pend_nx;
      perf_d <= perf_stat;
      if (clr_wr) clr_q <= clr_wdata;
    end
  end

  assign irq_oe = |pend_q;
  assign irq_n  = ~irq_oe;

endmodule

// File: rtl/irq_sticky_ctrl_chk.sv
module irq_sticky_ctrl_chk #(
  parameter int PERF_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ovf_pulse,
  input logic              unf_pulse,
  input logic              gie,
  input logic              tsr_rd,
  input logic              clr_wr,
  input logic [1:0]        tsr_q,
  input logic [PERF_W+1:0] clr_q,
  input logic              irq_n,
  input logic              irq_oe
);

  a_r1_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_q[0] && !tsr_rd |=> tsr_q[0]);

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tsr_rd && !ovf_pulse |=> !tsr_q[0]);

  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    unf_pulse && tsr_rd |=> tsr_q[1]);

  a_r4_es_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse && !clr_q[0] |=> irq_oe);

  a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&clr_q) && !irq_oe && !clr_wr |=> !irq_oe);

  a_r9_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe && !gie && !ovf_pulse && !unf_pulse |=> !irq_oe);

  a_r10_pin_low_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> !irq_n);

endmodule

bind irq_sticky_ctrl irq_sticky_ctrl_chk #(.PERF_W(PERF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse),
  .gie(gie), .tsr_rd(tsr_rd), .clr_wr(clr_wr), .tsr_q(tsr_q),
  .clr_q(clr_q), .irq_n(irq_n), .irq_oe(irq_oe)
);

// File: tb/tb_irq_sticky_ctrl.sv
module tb_irq_sticky_ctrl;
  localparam int PW = 4;
  localparam int NS = PW + 2;
  localparam int NV = 30;

  logic clk = 0, rst_n = 0;
  logic ovf = 0, unf = 0, gie = 0, rd = 0, wr = 0;
  logic [PW-1:0] perf = '0;
  logic [NS-1:0] wd = '0;
  logic [1:0] tsr;
  logic [NS-1:0] clr;
  logic irq_n, irq_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_sticky_ctrl #(.PERF_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf), .unf_pulse(unf),
    .perf_stat(perf), .gie(gie), .tsr_rd(rd), .clr_wr(wr), .clr_wdata(wd),
    .tsr_q(tsr), .clr_q(clr), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  typedef struct packed {
    logic ovf, unf;
    logic [3:0] perf;
    logic gie, rd, wr;
    logic [5:0] wd;
    logic [1:0] etsr;
    logic eoe;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd11}, // R11 idle
    '{1'b1,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b01,1'b1,4'd4},  // R4 overflow
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b01,1'b1,4'd1},  // R1 held
    '{1'b0,1'b0,4'b0000,1'b1,1'b1,1'b0,6'b000000,2'b00,1'b1,4'd2},  // R2 read
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b1,6'b000001,2'b00,1'b1,4'd6},  // R6 write
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd6},  // R6 drops
    '{1'b1,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b01,1'b0,4'd5},  // R5 masked
    '{1'b1,1'b1,4'b0000,1'b1,1'b1,1'b0,6'b000000,2'b11,1'b1,4'd3},  // R3 wins
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b1,6'b000010,2'b11,1'b1,4'd6},  // R6
    '{1'b0,1'b1,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b11,1'b1,4'd6},  // R6 cause
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b11,1'b0,4'd6},  // R6 gone
    '{1'b1,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b11,1'b1,4'd7},  // R7 re-en
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b1,6'b000011,2'b11,1'b1,4'd6},
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b11,1'b0,4'd6},
    '{1'b0,1'b0,4'b0000,1'b1,1'b1,1'b1,6'b000000,2'b00,1'b0,4'd2},
    '{1'b0,1'b0,4'b0001,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b1,4'd8},  // R8 rise
    '{1'b0,1'b0,4'b0001,1'b1,1'b0,1'b1,6'b000100,2'b00,1'b1,4'd6},
    '{1'b0,1'b0,4'b0001,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd6},
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd5},
    '{1'b0,1'b0,4'b0000,1'b1,1'b0,1'b1,6'b000000,2'b00,1'b0,4'd7},
    '{1'b0,1'b0,4'b1000,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b1,4'd8},  // R8 top bit
    '{1'b0,1'b0,4'b1000,1'b1,1'b0,1'b1,6'b100000,2'b00,1'b1,4'd6},
    '{1'b0,1'b0,4'b1000,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd6},
    '{1'b0,1'b0,4'b1000,1'b0,1'b0,1'b1,6'b000000,2'b00,1'b0,4'd9},
    '{1'b0,1'b0,4'b1001,1'b0,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd9},  // R9 gated
    '{1'b0,1'b0,4'b1001,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd9},
    '{1'b0,1'b0,4'b0001,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b1,4'd8},  // R8 fall
    '{1'b0,1'b0,4'b0001,1'b1,1'b0,1'b1,6'b100000,2'b00,1'b1,4'd6},
    '{1'b0,1'b0,4'b0001,1'b1,1'b0,1'b0,6'b000000,2'b00,1'b0,4'd6},
    '{1'b0,1'b0,4'b0001,1'b1,1'b0,1'b1,6'b000000,2'b00,1'b0,4'd7}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pins(input string req, input logic [1:0] et, input logic eo);
    chk(req, {6'd0, tsr}, {6'd0, et});
    chk(req, {7'd0, irq_oe}, {7'd0, eo});
    chk({req, "_R10"}, {7'd0, irq_n}, {7'd0, ~eo});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    pins("R11", 2'b00, 1'b0);
    chk("R11", {2'd0, clr}, 8'd0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ovf, unf, perf, gie, rd, wr, wd} =
        {VEC[i].ovf, VEC[i].unf, VEC[i].perf, VEC[i].gie, VEC[i].rd, VEC[i].wr, VEC[i].wd};
      @(posedge clk); #1;
      pins($sformatf("R%0d", VEC[i].req), VEC[i].etsr, VEC[i].eoe);
    end
    // R6 clear register contents after a write
    @(negedge clk); {ovf, rd, wr} = 3'b101; wd = 6'b000010;
    @(posedge clk); #1;
    pins("R4", 2'b01, 1'b1);
    chk("R6", {2'd0, clr}, 8'h02);
    // R11 reset mid-operation
    @(negedge clk); {ovf, wr} = 2'b00; perf = '0; rst_n = 0;
    #1;
    pins("R11", 2'b00, 1'b0);
    chk("R11", {2'd0, clr}, 8'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    pins("R11", 2'b00, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule